// File: doc/BRIEF.md
# Dual-Edge Capture Timer

The block timestamps both transitions of an external digital input against a 16-bit free-running counter clocked by the system clock. A falling transition copies the counter into a fall-stamp register; a rising transition copies it into a separate rise-stamp register. Because the two edges never share a register, both edges of one waveform are captured. The difference between a rise stamp and the following fall stamp gives the high time, and the difference between consecutive stamps of the same kind gives the period. A typical use is measuring the speed-feedback pulse train of a motor drive.

The asynchronous input passes through a two-flop synchroniser before edge detection. This delay is counted in the latency budget. Every capture raises an interrupt request, which stays high until it is acknowledged. If a new edge is captured while the request is still pending, an overrun flag is set. While the enable is low, the counter holds and input edges are ignored.

Top module: `edge_capture_timer`

## Requirements
- R1: A falling transition of `captIn` (1 to 0) loads `fallStamp` with the counter value and leaves `riseStamp` unchanged.
- R2: A rising transition of `captIn` (0 to 1) loads `riseStamp` with the counter value and leaves `fallStamp` unchanged.
- R3: Let N be the counter value at the first clock edge that samples the new input level. The stamp and `irqReq` are updated at the third clock edge from that edge, and the stamp holds N+2. This is within 4 clocks of the transition.
- R4: Each capture sets `irqReq`. `irqReq` stays high until a clock edge at which `irqAck` is 1 and no new capture happens; that edge clears it.
- R5: A capture that occurs while `irqReq` is high and `irqAck` is 0 sets `captOverrun`. A clock edge with `irqAck` at 1 clears `captOverrun`.
- R6: The counter is 16 bits wide. It advances by one every clock while enabled and wraps from 16'hFFFF to 16'h0000.
- R7: While `enable` is 0, the counter holds its value. Input transitions in that period load no stamp and raise no request, and none of them is captured late once `enable` returns to 1.
- R8: For any high and low times of at least 4 clocks each, the fall stamp minus the preceding rise stamp equals the high time, and the rise stamp minus the preceding fall stamp equals the low time, both modulo 2^16.
- R9: After reset, both stamps, the counter, `irqReq` and `captOverrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the counter and allows captures |
| captIn | input | 1 | Asynchronous input to be timestamped |
| irqAck | input | 1 | Clears the pending request and the overrun flag |
| fallStamp | output | 16 | Counter value at the last falling transition |
| riseStamp | output | 16 | Counter value at the last rising transition |
| irqReq | output | 1 | Capture interrupt request, held until acknowledged |
| captOverrun | output | 1 | A capture arrived while a request was pending |

## Verification
The bench sweeps every combination of high and low times from the 4-clock minimum up to 9 clocks, and checks each stamp against an exact count.

- A design with an extra or missing synchroniser stage would give stamps off by one, and a wrong difference between stamps would show up the same way.
- A design that loads a stamp on the wrong polarity, or loads both stamps on one edge, would corrupt the stamp that is meant to stay put.
- Placing a capture at the 16'hFFFF boundary exposes a counter that saturates instead of wrapping.
- A disabled window with a transition inside it exposes a design that keeps counting, or that captures the stale edge once enabled again.
- Two captures with no acknowledgement between them expose a missing or sticky overrun flag.

// File: rtl/capt_pkg.sv
`timescale 1ns/1ps
package capt_pkg;
  localparam int unsigned DEF_CNT_W = 16;

  // strobes issued by the control half to the datapath half
  typedef struct packed {
    logic countEn;
    logic loadFall;
    logic loadRise;
  } capt_strobe_t;
endpackage

// File: rtl/capt_ctrl.sv
`timescale 1ns/1ps
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         enable,
  input  logic         captIn,
  input  logic         irqAck,
  output capt_strobe_t strb,
  output logic         irqReq,
  output logic         captOverrun
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lastLvl;
  logic                   riseSeen;
  logic                   fallSeen;
  logic                   capHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      lastLvl <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], captIn};
      lastLvl <= syncQ[TOP];
    end
  end

  always_comb begin
    riseSeen      = syncQ[TOP] & ~lastLvl;
    fallSeen      = ~syncQ[TOP] & lastLvl;
    strb.countEn  = enable;
    strb.loadRise = enable & riseSeen;
    strb.loadFall = enable & fallSeen;
    capHit        = strb.loadRise | strb.loadFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqReq      <= 1'b0;
      captOverrun <= 1'b0;
    end else begin
      if (capHit)      irqReq <= 1'b1;
      else if (irqAck) irqReq <= 1'b0;

      if (irqAck)                captOverrun <= 1'b0;
      else if (capHit && irqReq) captOverrun <= 1'b1;
    end
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadFall, strb.loadRise})); // R1
  AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    capHit |=> irqReq); // R4
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (capHit && irqReq && !irqAck) |=> captOverrun); // R5
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> !captOverrun); // R5
  AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !capHit); // R7
endmodule

// File: rtl/capt_datapath.sv
`timescale 1ns/1ps
module capt_datapath
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  capt_strobe_t     strb,
  output logic [CNT_W-1:0] fallStamp,
  output logic [CNT_W-1:0] riseStamp
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      fallStamp <= '0;
      riseStamp <= '0;
    end else begin
      if (strb.countEn)  count     <= count + CNT_ONE;
      if (strb.loadFall) fallStamp <= count;
      if (strb.loadRise) riseStamp <= count;
    end
  end

  AST_COUNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && count == CNT_MAX) |=> count == '0); // R6
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.countEn |=> $stable(count)); // R7
  AST_RISE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadFall |=> $stable(riseStamp)); // R1
  AST_FALL_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRise |=> $stable(fallStamp)); // R2
endmodule

// File: rtl/edge_capture_timer.sv
`timescale 1ns/1ps
module edge_capture_timer
  import capt_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             captIn,
  input  logic             irqAck,
  output logic [CNT_W-1:0] fallStamp,
  output logic [CNT_W-1:0] riseStamp,
  output logic             irqReq,
  output logic             captOverrun
);
  capt_strobe_t strb;

  capt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .captIn      (captIn),
    .irqAck      (irqAck),
    .strb        (strb),
    .irqReq      (irqReq),
    .captOverrun (captOverrun)
  );

  capt_datapath #(.CNT_W(CNT_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .fallStamp (fallStamp),
    .riseStamp (riseStamp)
  );
endmodule

// File: tb/tb_edge_capture_timer.sv
`timescale 1ns/1ps
module tb_edge_capture_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        captIn = 1'b0;
  logic        irqAck = 1'b0;
  logic [15:0] fallStamp, riseStamp;
  logic        irqReq, captOverrun;

  int  tests = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [15:0] mRef;

  always #2 clk = ~clk;

  edge_capture_timer dut (
    .clk(clk), .rstN(rstN), .enable(enable), .captIn(captIn), .irqAck(irqAck),
    .fallStamp(fallStamp), .riseStamp(riseStamp), .irqReq(irqReq),
    .captOverrun(captOverrun)
  );

  // arithmetic reference: number of enabled clocks since reset, mod 2^16
  always @(posedge clk) begin
    if (!rstN) mRef <= 16'd0;
    else if (enable) mRef <= mRef + 16'd1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // called at a negedge: change the level, then wait out the capture latency
  task automatic edgeTo(input logic lvl, output logic [15:0] e);
    captIn = lvl;
    e = mRef + 16'd2;
    waitN(3);
  endtask

  task automatic pulseAck();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  initial begin
    logic [15:0] eR, eF, prevF, e1, e2;
    int lastLo;
    waitN(3);
    chk("R9 fallStamp", fallStamp, 0);
    chk("R9 riseStamp", riseStamp, 0);
    chk("R9 irqReq", irqReq, 0);
    chk("R9 captOverrun", captOverrun, 0);
    rstN = 1'b1;
    enable = 1'b1;
    waitN(5);
    chk("R9 no capture after reset", irqReq, 0);

    prevF = 16'd0;
    lastLo = -1;
    for (int hi = 4; hi <= 9; hi++) begin
      for (int lo = 4; lo <= 9; lo++) begin
        edgeTo(1'b1, eR);
        chk("R2 R3 riseStamp", riseStamp, eR);
        chk("R2 fallStamp kept", fallStamp, prevF);
        chk("R4 irq on rise", irqReq, 1);
        if (lastLo >= 0) chk("R8 low time", 16'(riseStamp - prevF), lastLo);
        pulseAck();
        waitN(hi - 4);
        edgeTo(1'b0, eF);
        chk("R1 R3 fallStamp", fallStamp, eF);
        chk("R1 riseStamp kept", riseStamp, eR);
        chk("R8 high time", 16'(fallStamp - riseStamp), hi);
        chk("R4 irq on fall", irqReq, 1);
        pulseAck();
        chk("R4 irq cleared", irqReq, 0);
        chk("R5 no overrun", captOverrun, 0);
        waitN(lo - 4);
        prevF = eF;
        lastLo = lo;
      end
    end

    // wrap boundary
    while (mRef != 16'hFFFF) @(negedge clk);
    edgeTo(1'b1, eR);
    chk("R6 wrap stamp", riseStamp, 16'h0001);
    chk("R6 wrap model", riseStamp, eR);
    pulseAck();

    // disabled window with a transition inside it
    waitN(4);
    enable = 1'b0;
    captIn = 1'b0;
    waitN(8);
    chk("R7 no irq while off", irqReq, 0);
    chk("R7 fallStamp kept", fallStamp, prevF);
    enable = 1'b1;
    waitN(4);
    chk("R7 no late capture", irqReq, 0);
    chk("R7 fallStamp still kept", fallStamp, prevF);
    edgeTo(1'b1, eR);
    chk("R7 counter held", riseStamp, eR);
    pulseAck();

    // overrun
    waitN(4);
    edgeTo(1'b0, e1);
    waitN(1);
    edgeTo(1'b1, e2);
    chk("R5 overrun set", captOverrun, 1);
    chk("R4 irq pending", irqReq, 1);
    chk("R1 fall of pair", fallStamp, e1);
    chk("R2 rise of pair", riseStamp, e2);
    pulseAck();
    chk("R5 overrun cleared", captOverrun, 0);
    chk("R4 irq cleared by ack", irqReq, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule